// File: doc/BRIEF.md
# Two-Level Hit Buffer with Clock-Domain Crossing

This block collects 32-bit hit words from several double-column readouts. The readouts all work at the same time on the slow column clock. Each column stream lands in its own shallow FIFO. A round-robin selector then moves up to four words per slow cycle into one shared chip FIFO. That FIFO crosses into a fast clock domain that runs at four times the column clock. There, the words leave one at a time on a single valid/ready stream.

Before a word goes into the chip FIFO, the selector writes the index of the column that sent it into the word's top ten bits. Downstream logic can therefore sort the hits without knowing which lane carried them. The payload below those ten bits holds the row and timestamp fields, and it passes through unchanged. A column whose FIFO is full sees its ready signal go low. A full chip FIFO stalls the selector. In both cases no word is lost. If a column still tries to write while its FIFO is full, a sticky per-column flag records it.

Top module: `hb_two_level_buf`

## Requirements
- R1: Each output word carries the source column index in bits [31:22], and bits [21:0] equal bits [21:0] of the word the column sent. Input bits [31:22] do not reach the output.
- R2: Each column FIFO stores 12 words. When the output is stalled and a single column keeps sending, that column accepts exactly 12 words plus one word for each chip FIFO entry (8 entries by default), and then its ready stays low.
- R3: A column's overflow flag goes high when the column holds valid while its ready is low. The flag stays high until reset, and no other column's flag changes.
- R4: Every accepted word appears at the output exactly once. Words from the same column keep their order, whatever pattern of output backpressure is applied.
- R5: When every column holds data, the column indices of the output words step through 0, 1, ..., N-1 in a repeating cycle, starting from column 0 after reset. Only columns that hold data are granted.
- R6: Up to 4 words move to the chip FIFO per column-clock cycle, which gives 160 words per microsecond at 40 MHz. Four columns that each send one word every cycle are never back-pressured, and 64 words per column are accepted within 68 cycles.
- R7: After reset, out_valid is low, every col_ready is high and every col_ovf is low.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_col | input | 1 | Column-side clock |
| rst_col_n | input | 1 | Asynchronous active-low reset, column domain |
| col_valid | input | N_COLS | Per-column word valid |
| col_data | input | N_COLS*32 | Per-column hit words, column c at bits [c*32 +: 32] |
| col_ready | output | N_COLS | Per-column ready, low while that column FIFO is full |
| col_ovf | output | N_COLS | Sticky per-column write-while-full flag |
| clk_out | input | 1 | Fast output clock |
| rst_out_n | input | 1 | Asynchronous active-low reset, output domain |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output word with column index stamped in [31:22] |
| out_ready | input | 1 | Downstream accepts the output word |

## Verification
A column FIFO whose pointer or level is wrong shows up within one drain as a lost, repeated or reordered word for that column. It can also show up as a ready that drops after the wrong number of accepted words. If the selector's rotation pointer is wrong, the repeating column sequence breaks on the first full round of output words. If a chip FIFO full or empty decision is off, a word is overwritten or read out twice. Either fault appears as a per-column sequence mismatch once the stalled output is released. A lane-count error splits or drops words inside a wide entry at the first entry that carries several lanes.

// File: rtl/hb_pkg.sv
`timescale 1ns/1ps
package hb_pkg;
  localparam int HIT_W     = 32;
  localparam int COL_IDX_W = 10;
  localparam int PAYLOAD_W = HIT_W - COL_IDX_W;

  // Replace the top bits of a hit with the index of its source column.
  function automatic logic [HIT_W-1:0] tag_hit(input int col, input logic [HIT_W-1:0] hit);
    logic [COL_IDX_W-1:0] idx;
    idx = COL_IDX_W'(col);
    return {idx, hit[PAYLOAD_W-1:0]};
  endfunction

  // Position 'off' steps after 'base' on a ring of n slots.
  function automatic int rr_index(input int base, input int off, input int n);
    int s;
    s = base + off;
    if (s >= n) s = s - n;
    return s;
  endfunction
endpackage

// File: rtl/hb_col_fifo.sv
`timescale 1ns/1ps
module hb_col_fifo #(
  parameter int DEPTH = 12,
  parameter int W     = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  output logic          in_ready,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic [CW-1:0] level,
  output logic          ovf
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          push, take;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign in_ready = (level != CW'(DEPTH));
  assign empty    = (level == '0);
  assign push     = in_valid && in_ready;
  assign take     = pop && !empty;
  assign head     = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
      ovf   <= 1'b0;
    end else begin
      if (push) wp <= step(wp);
      if (take) rp <= step(rp);
      level <= level + CW'(push) - CW'(take);
      if (in_valid && !in_ready) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end
endmodule

// File: rtl/hb_rr_pick.sv
`timescale 1ns/1ps
module hb_rr_pick
  import hb_pkg::*;
#(
  parameter int N     = 8,
  parameter int LANES = 4,
  parameter int W     = 32,
  localparam int NW   = (N > 1) ? $clog2(N) : 1,
  localparam int LCW  = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      avail,
  input  logic [N*W-1:0]    heads,
  input  logic              room,
  output logic [N-1:0]      grant,
  output logic [LANES*W-1:0] lanes,
  output logic [LCW-1:0]    used,
  output logic              fire
);
  logic [NW-1:0] ptr;
  int            pick;
  int            last;

  // Walk the ring from ptr; pack up to LANES words into the low lanes.
  always_comb begin
    grant = '0;
    lanes = '0;
    used  = '0;
    last  = int'(ptr);
    pick  = 0;
    for (int i = 0; i < N; i++) begin
      pick = rr_index(int'(ptr), i, N);
      if (room && avail[pick] && (used < LCW'(LANES))) begin
        grant[pick] = 1'b1;
        lanes[int'(used)*W +: W] = tag_hit(pick, heads[pick*W +: W]);
        used = used + 1'b1;
        last = pick;
      end
    end
  end

  assign fire = (used != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (fire) ptr <= NW'(rr_index(last, 1, N));
  end
endmodule

// File: rtl/hb_gray_fifo.sv
`timescale 1ns/1ps
module hb_gray_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic         wfull,
  input  logic         rclk,
  input  logic         rrst_n,
  input  logic         rd_en,
  output logic [W-1:0] rdata,
  output logic         rempty
);
  function automatic logic [AW:0] to_gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wbin, wgray, wbin_nx, rg_w1, rg_w2;
  logic [AW:0]  rbin, rgray, rbin_nx, wg_r1, wg_r2;
  logic         wput, rget;

  assign wput    = wr_en && !wfull;
  assign rget    = rd_en && !rempty;
  assign wbin_nx = wbin + (AW+1)'(wput);
  assign rbin_nx = rbin + (AW+1)'(rget);

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rg_w1 <= '0;
      rg_w2 <= '0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= to_gray(wbin_nx);
      rg_w1 <= rgray;
      rg_w2 <= rg_w1;
    end
  end

  assign wfull = (wgray == {~rg_w2[AW:AW-1], rg_w2[AW-2:0]});

  always_ff @(posedge wclk) begin
    if (wput) mem[wbin[AW-1:0]] <= wdata;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
      wg_r1 <= '0;
      wg_r2 <= '0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= to_gray(rbin_nx);
      wg_r1 <= wgray;
      wg_r2 <= wg_r1;
    end
  end

  assign rempty = (rgray == wg_r2);
  assign rdata  = mem[rbin[AW-1:0]];
endmodule

// File: rtl/hb_lane_unpack.sv
`timescale 1ns/1ps
module hb_lane_unpack #(
  parameter int LANES = 4,
  parameter int W     = 32,
  localparam int LCW  = $clog2(LANES + 1),
  localparam int LSW  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LCW+LANES*W-1:0] entry,
  input  logic                   have,
  output logic                   out_valid,
  output logic [W-1:0]           out_data,
  input  logic                   out_ready,
  output logic                   pop
);
  logic [LSW-1:0] sel;
  logic [LCW-1:0] cnt;
  logic           last_lane, xfer;

  assign cnt       = entry[LCW+LANES*W-1 -: LCW];
  assign out_valid = have;
  assign out_data  = entry[int'(sel)*W +: W];
  assign last_lane = ((LCW'(sel) + 1'b1) >= cnt);
  assign xfer      = have && out_ready;
  assign pop       = xfer && last_lane;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel <= '0;
    else if (xfer) sel <= last_lane ? '0 : sel + 1'b1;
  end
endmodule

// File: rtl/hb_two_level_buf.sv
`timescale 1ns/1ps
module hb_two_level_buf #(
  parameter int N_COLS     = 8,
  parameter int COL_DEPTH  = 12,
  parameter int CHIP_DEPTH = 8,
  parameter int LANES      = 4
) (
  input  logic                           clk_col,
  input  logic                           rst_col_n,
  input  logic [N_COLS-1:0]              col_valid,
  input  logic [N_COLS*hb_pkg::HIT_W-1:0] col_data,
  output logic [N_COLS-1:0]              col_ready,
  output logic [N_COLS-1:0]              col_ovf,
  input  logic                           clk_out,
  input  logic                           rst_out_n,
  output logic                           out_valid,
  output logic [hb_pkg::HIT_W-1:0]       out_data,
  input  logic                           out_ready
);
  localparam int W     = hb_pkg::HIT_W;
  localparam int CNT_W = $clog2(COL_DEPTH + 1);
  localparam int LCW   = $clog2(LANES + 1);
  localparam int ENT_W = LCW + LANES * W;

  // Named internal events, observed by the bound checker.
  logic [N_COLS-1:0]       col_empty, col_avail, col_grant;
  logic [N_COLS*W-1:0]     col_head;
  logic [N_COLS*CNT_W-1:0] col_level;
  logic                    chip_full, chip_push, chip_empty, chip_pop;
  logic [LANES*W-1:0]      lane_words;
  logic [LCW-1:0]          lane_used;
  logic [ENT_W-1:0]        chip_in, chip_out;

  generate
    for (genvar g = 0; g < N_COLS; g++) begin : g_col
      hb_col_fifo #(.DEPTH(COL_DEPTH), .W(W)) u_fifo (
        .clk      (clk_col),
        .rst_n    (rst_col_n),
        .in_valid (col_valid[g]),
        .in_data  (col_data[g*W +: W]),
        .in_ready (col_ready[g]),
        .pop      (col_grant[g]),
        .head     (col_head[g*W +: W]),
        .empty    (col_empty[g]),
        .level    (col_level[g*CNT_W +: CNT_W]),
        .ovf      (col_ovf[g])
      );
    end
  endgenerate

  assign col_avail = ~col_empty;

  hb_rr_pick #(.N(N_COLS), .LANES(LANES), .W(W)) u_pick (
    .clk   (clk_col),
    .rst_n (rst_col_n),
    .avail (col_avail),
    .heads (col_head),
    .room  (!chip_full),
    .grant (col_grant),
    .lanes (lane_words),
    .used  (lane_used),
    .fire  (chip_push)
  );

  assign chip_in = {lane_used, lane_words};

  hb_gray_fifo #(.W(ENT_W), .DEPTH(CHIP_DEPTH)) u_chip (
    .wclk   (clk_col),
    .wrst_n (rst_col_n),
    .wr_en  (chip_push),
    .wdata  (chip_in),
    .wfull  (chip_full),
    .rclk   (clk_out),
    .rrst_n (rst_out_n),
    .rd_en  (chip_pop),
    .rdata  (chip_out),
    .rempty (chip_empty)
  );

  hb_lane_unpack #(.LANES(LANES), .W(W)) u_unpack (
    .clk       (clk_out),
    .rst_n     (rst_out_n),
    .entry     (chip_out),
    .have      (!chip_empty),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .pop       (chip_pop)
  );
endmodule

// File: rtl/hb_buf_checker.sv
`timescale 1ns/1ps
module hb_buf_checker #(
  parameter int N     = 8,
  parameter int DEPTH = 12,
  parameter int LANES = 4,
  parameter int CW    = 4
) (
  input logic                     clk_col,
  input logic                     rst_col_n,
  input logic                     clk_out,
  input logic                     rst_out_n,
  input logic [N-1:0]             grant,
  input logic [N-1:0]             empty,
  input logic                     chip_full,
  input logic [N*CW-1:0]          level,
  input logic [N-1:0]             col_ovf,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [hb_pkg::HIT_W-1:0] out_data
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_c
      // R2: a column never holds more than its depth
      a_r2_level_bound: assert property (@(posedge clk_col) disable iff (!rst_col_n)
        level[i*CW +: CW] <= CW'(DEPTH));
      // R2: a full column that is not drained stays full (no write slips in)
      a_r2_full_holds: assert property (@(posedge clk_col) disable iff (!rst_col_n)
        (level[i*CW +: CW] == CW'(DEPTH) && !grant[i]) |=> (level[i*CW +: CW] == CW'(DEPTH)));
      // R3: overflow flag is sticky
      a_r3_ovf_sticky: assert property (@(posedge clk_col) disable iff (!rst_col_n)
        col_ovf[i] |=> col_ovf[i]);
    end
  endgenerate

  // R4: a full chip FIFO stalls every column
  a_r4_full_no_grant: assert property (@(posedge clk_col) disable iff (!rst_col_n)
    chip_full |-> (grant == '0));

  // R5: only columns holding data are granted
  a_r5_grant_nonempty: assert property (@(posedge clk_col) disable iff (!rst_col_n)
    (grant & empty) == '0);

  // R6: at most LANES words move per cycle
  a_r6_lane_limit: assert property (@(posedge clk_col) disable iff (!rst_col_n)
    $countones(grant) <= LANES);

  // R8: a stalled output word holds
  a_r8_hold_out: assert property (@(posedge clk_out) disable iff (!rst_out_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind hb_two_level_buf hb_buf_checker #(
  .N(N_COLS), .DEPTH(COL_DEPTH), .LANES(LANES), .CW(CNT_W)
) u_chk (
  .clk_col   (clk_col),
  .rst_col_n (rst_col_n),
  .clk_out   (clk_out),
  .rst_out_n (rst_out_n),
  .grant     (col_grant),
  .empty     (col_empty),
  .chip_full (chip_full),
  .level     (col_level),
  .col_ovf   (col_ovf),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/sim_hb_two_level_buf.sv
`timescale 1ns/1ps
module sim_hb_two_level_buf;
  localparam int N = 8;
  localparam int W = 32;

  logic clk_col = 1'b0;
  logic clk_out = 1'b0;
  always #10  clk_col = ~clk_col;
  always #2.5 clk_out = ~clk_out;

  logic             rst_col_n = 1'b0;
  logic             rst_out_n = 1'b0;
  logic [N-1:0]     col_valid = '0;
  logic [N*W-1:0]   col_data = '0;
  logic [N-1:0]     col_ready, col_ovf;
  logic             out_valid;
  logic [W-1:0]     out_data;
  logic             out_ready = 1'b0;

  hb_two_level_buf u0 (
    .clk_col   (clk_col),
    .rst_col_n (rst_col_n),
    .col_valid (col_valid),
    .col_data  (col_data),
    .col_ready (col_ready),
    .col_ovf   (col_ovf),
    .clk_out   (clk_out),
    .rst_out_n (rst_out_n),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready)
  );

  int n_chk = 0;
  int n_bad = 0;
  int bp_mode = 2;
  int bp_cnt = 0;

  logic [W-1:0] src_q [N][$];
  logic [W-1:0] exp_q [N][$];
  logic [W-1:0] got_q [$];
  logic [N-1:0] acc = '0;
  logic [N-1:0] blocked_seen = '0;

  // Column drivers: show queue heads, retire accepted words.
  always @(posedge clk_col) begin
    #1;
    for (int c = 0; c < N; c++) begin
      if (acc[c] && src_q[c].size() > 0) void'(src_q[c].pop_front());
      col_valid[c] = (src_q[c].size() > 0);
      col_data[c*W +: W] = (src_q[c].size() > 0) ? src_q[c][0] : '0;
    end
  end

  // Column monitor: record accepted words with the expected stamp.
  always @(negedge clk_col) begin
    for (int c = 0; c < N; c++) begin
      acc[c] = rst_col_n && col_valid[c] && col_ready[c];
      if (acc[c]) exp_q[c].push_back({10'(c), col_data[c*W +: 22]});
      if (rst_col_n && col_valid[c] && !col_ready[c]) blocked_seen[c] = 1'b1;
    end
  end

  // Output ready pattern.
  always @(posedge clk_out) begin
    #1;
    bp_cnt++;
    case (bp_mode)
      0:       out_ready = 1'b1;
      1:       out_ready = ((bp_cnt % 3) == 0);
      default: out_ready = 1'b0;
    endcase
  end

  // Output monitor.
  always @(negedge clk_out) begin
    if (rst_out_n && out_valid && out_ready) got_q.push_back(out_data);
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [W-1:0] mk_word(input int c, input int k, input int seed);
    return {10'(k*37 + 3 + seed), 10'(k + c*16), 12'(seed*7 + k)};
  endfunction

  function automatic bit any_src();
    for (int c = 0; c < N; c++) if (src_q[c].size() > 0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic load(input int c, input int n, input int seed);
    for (int k = 0; k < n; k++) src_q[c].push_back(mk_word(c, k, seed));
  endtask

  task automatic do_reset();
    for (int c = 0; c < N; c++) src_q[c].delete();
    bp_mode = 2;
    @(posedge clk_col);
    #2;
    rst_col_n = 1'b0;
    rst_out_n = 1'b0;
    repeat (3) @(posedge clk_col);
    for (int c = 0; c < N; c++) exp_q[c].delete();
    got_q.delete();
    blocked_seen = '0;
    @(posedge clk_col);
    #2;
    rst_col_n = 1'b1;
    rst_out_n = 1'b1;
    repeat (2) @(posedge clk_col);
  endtask

  task automatic wait_got(input int n, input int limit);
    int t = 0;
    while (got_q.size() < n && t < limit) begin
      @(posedge clk_col);
      t++;
    end
  endtask

  // R4: per-column order and completeness.
  task automatic verify_columns(input string tag);
    for (int c = 0; c < N; c++) begin
      logic [W-1:0] mine [$];
      int bad = 0;
      for (int k = 0; k < got_q.size(); k++)
        if (got_q[k][31:22] == 10'(c)) mine.push_back(got_q[k]);
      chk(mine.size() == exp_q[c].size(), tag, 64'(mine.size()), 64'(exp_q[c].size()));
      for (int k = 0; k < mine.size() && k < exp_q[c].size(); k++)
        if (mine[k] != exp_q[c][k]) bad++;
      chk(bad == 0, tag, 64'(bad), 64'd0);
    end
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk_out);
    chk(out_valid == 1'b0, "R7 out_valid after reset", 64'(out_valid), 64'd0);
    chk(col_ready == '1, "R7 col_ready after reset", 64'(col_ready), 64'hFF);
    chk(col_ovf == '0, "R7 col_ovf after reset", 64'(col_ovf), 64'd0);
  endtask

  task automatic t_stamp();
    do_reset();
    bp_mode = 0;
    load(5, 3, 11);
    wait_got(3, 200);
    chk(got_q.size() == 3, "R1 word count", 64'(got_q.size()), 64'd3);
    for (int k = 0; k < 3 && k < got_q.size(); k++) begin
      logic [W-1:0] e;
      e = {10'd5, mk_word(5, k, 11)};
      e = {10'd5, e[21:0]};
      chk(got_q[k] == e, "R1 stamped word", 64'(got_q[k]), 64'(e));
    end
  endtask

  task automatic t_fill();
    logic v1, v2;
    logic [W-1:0] d1, d2;
    do_reset();
    bp_mode = 2;
    load(2, 30, 5);
    repeat (60) @(posedge clk_col);
    chk(exp_q[2].size() == 20, "R2 words accepted while stalled", 64'(exp_q[2].size()), 64'd20);
    @(negedge clk_col);
    chk(col_ready[2] == 1'b0, "R2 ready low when full", 64'(col_ready[2]), 64'd0);
    chk(col_ovf == 8'b0000_0100, "R3 only blocked column flagged", 64'(col_ovf), 64'h4);
    @(negedge clk_out);
    v1 = out_valid;
    d1 = out_data;
    repeat (10) @(negedge clk_out);
    v2 = out_valid;
    d2 = out_data;
    chk(v1 && v2, "R8 valid held under stall", 64'({v1, v2}), 64'h3);
    chk(d1 == d2, "R8 data stable under stall", 64'(d2), 64'(d1));
    chk(d1 == exp_q[2][0], "R8 stalled word is first word", 64'(d1), 64'(exp_q[2][0]));
    bp_mode = 1;
    wait_got(30, 2000);
    verify_columns("R4 drain after stall");
    chk(col_ovf[2] == 1'b1, "R3 flag sticky after drain", 64'(col_ovf[2]), 64'd1);
  endtask

  task automatic t_rr();
    do_reset();
    bp_mode = 0;
    for (int c = 0; c < N; c++) load(c, 3, 20 + c);
    wait_got(24, 400);
    chk(got_q.size() == 24, "R5 word count", 64'(got_q.size()), 64'd24);
    for (int k = 0; k < 24 && k < got_q.size(); k++)
      chk(got_q[k][31:22] == 10'(k % N), "R5 round-robin column order",
          64'(got_q[k][31:22]), 64'(k % N));
    verify_columns("R4 round-robin contents");
  endtask

  task automatic t_rate();
    int cycles = 0;
    do_reset();
    bp_mode = 0;
    for (int c = 1; c < N; c += 2) load(c, 64, 40 + c);
    while (any_src() && cycles < 400) begin
      @(posedge clk_col);
      cycles++;
    end
    chk(cycles <= 68, "R6 cycles to accept 4x64 words", 64'(cycles), 64'd68);
    wait_got(256, 1000);
    chk(blocked_seen == '0, "R6 no column back-pressured", 64'(blocked_seen), 64'd0);
    chk(col_ovf == '0, "R6 no overflow at full rate", 64'(col_ovf), 64'd0);
    verify_columns("R4 full-rate contents");
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_stamp();
    t_fill();
    t_rr();
    t_rate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule